// File: doc/BRIEF.md
# Register-Immediate ALU with Zero Flag

This block is the execute stage for the logic and arithmetic instructions of a small 8-bit I/O processor. Each instruction supplies a register operand, an immediate operand and an operation code. The block works out the result as combinational logic. It also decides whether that result goes back into the register file, and it keeps the single condition bit that the branch logic tests: a zero flag, held in a register.

Exclusive-OR, OR, AND and ADD combine the register with the immediate and ask for a write-back. Compare subtracts the immediate from the register. It changes only the zero flag and never writes. A no-operation is an OR with immediate zero. It therefore leaves the register as it was, but it still reloads the zero flag from that register.

The zero flag changes only at a clock edge where the execute strobe is high and the operation code is one of the five ALU codes. The block takes one instruction in each cycle the strobe is high and never stalls. There is no back-pressure, so the strobe is a plain control pin rather than a valid/ready pair.

Top module: `imm_alu`

## Requirements
- R1: Operation code 0 gives result_o equal to reg_i XOR imm_i.
- R2: Operation code 1 gives result_o equal to reg_i OR imm_i.
- R3: Operation code 2 gives result_o equal to reg_i AND imm_i.
- R4: Operation code 3 gives result_o equal to (reg_i + imm_i) modulo 256, with no carry output.
- R5: wr_en_o is high exactly when exec_i is high and the operation code is 0, 1, 2 or 3.
- R6: Operation code 4 (compare) gives result_o equal to (reg_i - imm_i) modulo 256, keeps wr_en_o low, and sets the zero flag when reg_i equals imm_i.
- R7: After a clock edge with exec_i high and an operation code from 0 to 4, zero_o is 1 if the result_o of that cycle was 0, and 0 otherwise.
- R8: zero_o keeps its value across any clock edge where exec_i is low or the operation code is 5, 6 or 7. For codes 5 to 7, result_o equals reg_i and wr_en_o is low.
- R9: While rst_n is low, zero_o is 0.
- R10: An OR with immediate 0x00 (no-operation) gives result_o equal to reg_i. It sets zero_o when reg_i is 0 and clears zero_o otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe, one instruction per high cycle |
| op_i | input | 3 | Operation code: 0 XOR, 1 OR, 2 AND, 3 ADD, 4 compare |
| reg_i | input | 8 | Register operand |
| imm_i | input | 8 | Immediate operand |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Register write-back enable |
| zero_o | output | 1 | Registered zero flag |

## Verification
The only state in the block is the zero flag. A wrong flag shows on zero_o at the first falling edge after the clock edge that loaded it, and it stays visible until the next ALU instruction. Holds and reloads are therefore checked half a cycle after each edge. A fault in the operation decode shows at once on result_o or wr_en_o, in the same cycle the code is applied. Such a fault also reaches zero_o one edge later. Compare is the case that tells a write-back fault apart from a flag fault.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_XOR = 3'd0,
    OP_OR  = 3'd1,
    OP_AND = 3'd2,
    OP_ADD = 3'd3,
    OP_CMP = 3'd4
  } alu_op_e;

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return op <= OP_ADD;
  endfunction

  function automatic logic op_flags(input logic [OP_W-1:0] op);
    return op <= OP_CMP;
  endfunction
endpackage

// File: rtl/imm_alu_bitwise.sv
module imm_alu_bitwise #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] and_o
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign xor_o[i] = a_i[i] ^ b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign and_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/imm_alu_addsub.sv
module imm_alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] cin;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign cin   = {{(W-1){1'b0}}, sub_i};
  assign sum_o = a_i + b_eff + cin;
endmodule

// File: rtl/imm_alu_zflag.sv
module imm_alu_zflag #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      zero_o <= 1'b0;
    else if (load_i) zero_o <= ~|value_i;
  end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    reg_i,
  input  logic [W-1:0]    imm_i,
  output logic [W-1:0]    result_o,
  output logic            wr_en_o,
  output logic            zero_o
);
  logic [W-1:0] xor_v, or_v, and_v, arith_v;
  logic         is_cmp;

  assign is_cmp = (op_i == OP_CMP);

  imm_alu_bitwise #(.W(W)) u_bitwise (
    .a_i(reg_i), .b_i(imm_i), .xor_o(xor_v), .or_o(or_v), .and_o(and_v)
  );

  imm_alu_addsub #(.W(W)) u_addsub (
    .a_i(reg_i), .b_i(imm_i), .sub_i(is_cmp), .sum_o(arith_v)
  );

  always_comb begin
    case (op_i)
      OP_XOR:         result_o = xor_v;
      OP_OR:          result_o = or_v;
      OP_AND:         result_o = and_v;
      OP_ADD, OP_CMP: result_o = arith_v;
      default:        result_o = reg_i;
    endcase
  end

  assign wr_en_o = exec_i & op_writes(op_i);

  imm_alu_zflag #(.W(W)) u_zflag (
    .clk(clk), .rst_n(rst_n),
    .load_i(exec_i & op_flags(op_i)),
    .value_i(result_o),
    .zero_o(zero_o)
  );
endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] reg_i,
  input logic [W-1:0] imm_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic         zero_o
);
  // R5
  wr_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |-> !wr_en_o);
  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 3'd4) |-> !wr_en_o);
  // R6
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 3'd4) |=> (zero_o == ($past(reg_i) == $past(imm_i))));
  // R7
  zero_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i <= 3'd4) |=> (zero_o == ($past(result_o) == '0)));
  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i || op_i > 3'd4) |=> $stable(zero_o));
  // R10
  nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && imm_i == '0) |-> (result_o == reg_i));
endmodule

bind imm_alu imm_alu_chk #(.W(W)) u_chk (.*);

// File: tb/imm_alu_bench.sv
module imm_alu_bench;
  localparam int W = 8;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [W-1:0] reg_i = '0, imm_i = '0;
  logic [W-1:0] result_o;
  logic wr_en_o, zero_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  imm_alu #(.W(W)) u_imm_alu (.*);

  // {op, reg, imm, result, wr_en, zero-after}
  localparam logic [28:0] VECS [NV] = '{
    {3'd0, 8'h5A, 8'hFF, 8'hA5, 1'b1, 1'b0},  // R1
    {3'd0, 8'h3C, 8'h3C, 8'h00, 1'b1, 1'b1},  // R1
    {3'd1, 8'h10, 8'h01, 8'h11, 1'b1, 1'b0},  // R2
    {3'd1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},  // R10
    {3'd1, 8'h81, 8'h00, 8'h81, 1'b1, 1'b0},  // R10
    {3'd2, 8'hF0, 8'h0F, 8'h00, 1'b1, 1'b1},  // R3
    {3'd2, 8'hF3, 8'h3F, 8'h33, 1'b1, 1'b0},  // R3
    {3'd3, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},  // R4
    {3'd3, 8'h12, 8'h34, 8'h46, 1'b1, 1'b0},  // R4
    {3'd3, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},  // R4
    {3'd4, 8'h00, 8'h01, 8'hFF, 1'b0, 1'b0},  // R6
    {3'd4, 8'h42, 8'h42, 8'h00, 1'b0, 1'b1},  // R6
    {3'd4, 8'h42, 8'h43, 8'hFF, 1'b0, 1'b0}   // R6
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: zero flag during reset
    #5 check("R9", {7'd0, zero_o}, 8'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op_i, reg_i, imm_i} = VECS[i][28:10];
      exec_i = 1'b1;
      #1;
      check("R1-4/R6/R10 result", result_o, VECS[i][9:2]);
      check("R5 wr_en", {7'd0, wr_en_o}, {7'd0, VECS[i][1]});
      @(negedge clk);
      exec_i = 1'b0;
      check("R7 zero", {7'd0, zero_o}, {7'd0, VECS[i][0]});
    end

    // Set flag with equal compare, then R8 holds
    @(negedge clk);
    op_i = 3'd4; reg_i = 8'h07; imm_i = 8'h07; exec_i = 1'b1;
    @(negedge clk);
    check("R6 cmp equal", {7'd0, zero_o}, 8'd1);
    op_i = 3'd0; reg_i = 8'h01; imm_i = 8'h00; exec_i = 1'b0;
    #1 check("R5 no exec", {7'd0, wr_en_o}, 8'd0);
    @(negedge clk);
    check("R8 hold exec low", {7'd0, zero_o}, 8'd1);
    op_i = 3'd6; reg_i = 8'h9C; exec_i = 1'b1;
    #1 check("R8 unknown op result", result_o, 8'h9C);
    check("R8 unknown op wr_en", {7'd0, wr_en_o}, 8'd0);
    @(negedge clk);
    check("R8 hold unknown op", {7'd0, zero_o}, 8'd1);
    op_i = 3'd5;
    @(negedge clk);
    check("R8 hold op5", {7'd0, zero_o}, 8'd1);
    // R10: nop on nonzero clears flag
    op_i = 3'd1; reg_i = 8'h40; imm_i = 8'h00;
    @(negedge clk);
    check("R10 nop clears", {7'd0, zero_o}, 8'd0);
    // R10 then R9: nop on zero sets, reset clears
    reg_i = 8'h00;
    @(negedge clk);
    check("R10 nop sets", {7'd0, zero_o}, 8'd1);
    exec_i = 1'b0;
    rst_n = 1'b0;
    #1 check("R9 mid-run reset", {7'd0, zero_o}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule